// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Controller

This block builds the 8-bit status byte of a programmable instrument from summary flags that come from elsewhere in the chip. These flags are error queue not empty, questionable summary, message available and operation summary. The block also holds the standard event register and its enable mask, and ANDs them together to form the event summary bit of the status byte. A writable service request enable mask selects which status bits raise the master summary. The block keeps a latched request-for-service flag for the controller.

There are two read paths. The live query output reports the master summary in bit 6. The serial-poll output reports the latched request flag in bit 6, and strobing a poll clears that flag. Reading the standard event register returns its contents and empties it. Events that arrive in the same cycle as the read are kept for the next read.

Top module: `stb_srq_ctrl`

## Requirements
- R1: The status byte carries error-queue-not-empty in bit 2, questionable summary in bit 3, message available in bit 4, event summary in bit 5 and operation summary in bit 7. Bits 0 and 1 read 0. These bits follow their inputs in the same cycle on both read paths.
- R2: A high pulse on `std_evt_i[k]` sets event register bit k at the next clock edge, and the bit stays set. Only bits 7, 5, 4, 3, 2 and 0 exist. Pulses on bits 6 and 1 are ignored, and those bits read 0.
- R3: While `esr_rd_i` is high, `esr_rdata_o` shows the current register contents. At the next edge the register is cleared, except for events pulsed in that same cycle, which are kept.
- R4: The event summary (status bit 5) is the OR of the event register ANDed with the event enable mask. A write to the enable mask takes effect at the next edge.
- R5: The service request enable mask is written through `sre_we_i` and takes effect at the next edge. Its bit 6 always reads 0 and has no effect on the master summary.
- R6: The master summary `mss_o` is the OR of the status byte ANDed with the service request enable mask. It appears in bit 6 of `stb_query_o` in the same cycle.
- R7: A rising edge of the master summary sets `srq_o` one clock later. The flag stays set after the master summary falls, and a live query does not clear it.
- R8: `spoll_data_o` has `srq_o` in bit 6 and the live status bits elsewhere. A cycle with `spoll_i` high clears `srq_o` at the next edge.
- R9: If a serial poll coincides with a rising edge of the master summary, `srq_o` stays set.
- R10: After a poll clears the flag, a master summary that stays high does not set it again. A new rising edge is needed.
- R11: Reset clears the event register, both enable masks, the request flag and the edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_q_ne_i | input | 1 | Error queue not empty |
| ques_sum_i | input | 1 | Questionable status summary |
| msg_avail_i | input | 1 | Output queue holds at least one byte |
| oper_sum_i | input | 1 | Operation status summary |
| std_evt_i | input | 8 | Standard event pulses, one per bit |
| ese_we_i | input | 1 | Event enable write strobe |
| ese_wdata_i | input | 8 | Event enable write data |
| ese_o | output | 8 | Event enable mask |
| esr_rd_i | input | 1 | Destructive event register read |
| esr_rdata_o | output | 8 | Event register contents |
| sre_we_i | input | 1 | Service request enable write strobe |
| sre_wdata_i | input | 8 | Service request enable write data |
| sre_o | output | 8 | Service request enable mask |
| spoll_i | input | 1 | Serial poll strobe |
| spoll_data_o | output | 8 | Serial poll response byte |
| stb_query_o | output | 8 | Live status byte query |
| mss_o | output | 1 | Master summary |
| srq_o | output | 1 | Latched request for service |

## Verification
The hardest case to reach is a serial poll in the same cycle as a new rising edge of the master summary. To reach it, the stimulus first latches the request flag and then drops the operation summary so that the flag is held with the master summary low. It then raises the operation summary and strobes the poll on the same negative edge. After that it holds the master summary high and polls again, to show that no new request appears without a fresh edge. A read of the event register is also paired with a new event pulse in the same cycle, so that both the cleared contents and the kept event can be seen.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int unsigned STB_W    = 8;
  localparam int unsigned BIT_ERRQ = 2;
  localparam int unsigned BIT_QUES = 3;
  localparam int unsigned BIT_MAV  = 4;
  localparam int unsigned BIT_ESB  = 5;
  localparam int unsigned BIT_RQS  = 6;
  localparam int unsigned BIT_OPER = 7;
  localparam logic [STB_W-1:0] ESR_IMPL = 8'hBD;
  localparam logic [STB_W-1:0] RQS_MASK = 8'h40;
  typedef logic [STB_W-1:0] stb_t;
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import stb_pkg::*;
#(
  parameter int unsigned W    = STB_W,
  parameter logic [W-1:0] IMPL = ESR_IMPL
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         rd_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] en_o,
  output logic         sum_o
);
  logic [W-1:0] evt_q, en_q, evt_m;

  assign evt_m = evt_i & IMPL;

  // read clears, but same-cycle arrivals survive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else if (rd_i) evt_q <= evt_m;
    else evt_q <= evt_q | evt_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign evt_o = evt_q;
  assign en_o  = en_q;
  assign sum_o = |(evt_q & en_q);
endmodule

// File: rtl/stb_assemble.sv
module stb_assemble
  import stb_pkg::*;
(
  input  logic err_q_ne_i,
  input  logic ques_sum_i,
  input  logic msg_avail_i,
  input  logic esb_i,
  input  logic oper_sum_i,
  output stb_t stb_o
);
  always_comb begin
    stb_o           = '0;
    stb_o[BIT_ERRQ] = err_q_ne_i;
    stb_o[BIT_QUES] = ques_sum_i;
    stb_o[BIT_MAV]  = msg_avail_i;
    stb_o[BIT_ESB]  = esb_i;
    stb_o[BIT_OPER] = oper_sum_i;
  end
endmodule

// File: rtl/srq_gen.sv
module srq_gen
  import stb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  stb_t stb_i,
  input  logic sre_we_i,
  input  stb_t sre_wdata_i,
  input  logic spoll_i,
  output stb_t sre_o,
  output logic mss_o,
  output logic rqs_o
);
  stb_t sre_q;
  logic mss, mss_q, rqs_q, mss_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sre_q <= '0;
    else if (sre_we_i) sre_q <= sre_wdata_i & ~RQS_MASK;
  end

  assign mss      = |(stb_i & sre_q);
  assign mss_rise = mss & ~mss_q;

  // new edge wins over a coinciding poll
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss;
      rqs_q <= (rqs_q & ~spoll_i) | mss_rise;
    end
  end

  assign sre_o = sre_q;
  assign mss_o = mss;
  assign rqs_o = rqs_q;
endmodule

// File: rtl/stb_srq_ctrl.sv
module stb_srq_ctrl
  import stb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       err_q_ne_i,
  input  logic       ques_sum_i,
  input  logic       msg_avail_i,
  input  logic       oper_sum_i,
  input  logic [7:0] std_evt_i,
  input  logic       ese_we_i,
  input  logic [7:0] ese_wdata_i,
  output logic [7:0] ese_o,
  input  logic       esr_rd_i,
  output logic [7:0] esr_rdata_o,
  input  logic       sre_we_i,
  input  logic [7:0] sre_wdata_i,
  output logic [7:0] sre_o,
  input  logic       spoll_i,
  output logic [7:0] spoll_data_o,
  output logic [7:0] stb_query_o,
  output logic       mss_o,
  output logic       srq_o
);
  logic esb, mss, rqs;
  stb_t stb_live;

  evt_status_reg #(.W(STB_W), .IMPL(ESR_IMPL)) u_esr (
    .clk_i, .rst_ni,
    .evt_i(std_evt_i), .rd_i(esr_rd_i),
    .en_we_i(ese_we_i), .en_wdata_i(ese_wdata_i),
    .evt_o(esr_rdata_o), .en_o(ese_o), .sum_o(esb)
  );

  stb_assemble u_asm (
    .err_q_ne_i, .ques_sum_i, .msg_avail_i,
    .esb_i(esb), .oper_sum_i, .stb_o(stb_live)
  );

  srq_gen u_srq (
    .clk_i, .rst_ni, .stb_i(stb_live),
    .sre_we_i, .sre_wdata_i, .spoll_i,
    .sre_o, .mss_o(mss), .rqs_o(rqs)
  );

  assign stb_query_o  = stb_live | (mss ? RQS_MASK : '0);
  assign spoll_data_o = stb_live | (rqs ? RQS_MASK : '0);
  assign mss_o        = mss;
  assign srq_o        = rqs;
endmodule

// File: rtl/stb_srq_chk.sv
module stb_srq_chk
  import stb_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] std_evt_i,
  input logic       esr_rd_i,
  input logic [7:0] esr_rdata_o,
  input logic [7:0] sre_o,
  input logic       spoll_i,
  input logic [7:0] spoll_data_o,
  input logic [7:0] stb_query_o,
  input logic       mss_o,
  input logic       srq_o
);
  a_r2_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esr_rdata_o & ~ESR_IMPL) == 8'h00);
  a_r3_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esr_rd_i |=> esr_rdata_o == $past(std_evt_i & ESR_IMPL));
  a_r5_sre_bit6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sre_o[BIT_RQS]);
  a_r6_mss_in_query: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_query_o[BIT_RQS] == mss_o);
  a_r7_rqs_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mss_o) |=> srq_o);
  a_r7_rqs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srq_o && !spoll_i) |=> srq_o);
  a_r8_poll_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spoll_i && !$rose(mss_o)) |=> !srq_o);
  a_r8_poll_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spoll_data_o[BIT_RQS] == srq_o && (spoll_data_o & ~RQS_MASK) == (stb_query_o & ~RQS_MASK));
endmodule

bind stb_srq_ctrl stb_srq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .std_evt_i(std_evt_i), .esr_rd_i(esr_rd_i),
  .esr_rdata_o(esr_rdata_o), .sre_o(sre_o), .spoll_i(spoll_i),
  .spoll_data_o(spoll_data_o), .stb_query_o(stb_query_o),
  .mss_o(mss_o), .srq_o(srq_o)
);

// File: tb/stb_srq_ctrl_tb.sv
module stb_srq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_q_ne = 0, ques_sum = 0, msg_avail = 0, oper_sum = 0;
  logic [7:0] std_evt = 0, ese_wdata = 0, sre_wdata = 0;
  logic ese_we = 0, esr_rd = 0, sre_we = 0, spoll = 0;
  logic [7:0] ese, esr, sre, spoll_data, query;
  logic mss, srq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  stb_srq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .err_q_ne_i(err_q_ne), .ques_sum_i(ques_sum),
    .msg_avail_i(msg_avail), .oper_sum_i(oper_sum), .std_evt_i(std_evt),
    .ese_we_i(ese_we), .ese_wdata_i(ese_wdata), .ese_o(ese),
    .esr_rd_i(esr_rd), .esr_rdata_o(esr), .sre_we_i(sre_we),
    .sre_wdata_i(sre_wdata), .sre_o(sre), .spoll_i(spoll),
    .spoll_data_o(spoll_data), .stb_query_o(query), .mss_o(mss), .srq_o(srq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    step(2);
    chk("R11 esr", esr, 8'h00);
    chk("R11 ese", ese, 8'h00);
    chk("R11 sre", sre, 8'h00);
    chk("R11 srq", {7'd0, srq}, 8'h00);
    chk("R11 query", query, 8'h00);
  endtask

  task automatic t_stb_bits();
    err_q_ne = 1; #1;
    chk("R1 errq bit2", query, 8'h04);
    err_q_ne = 0; ques_sum = 1; #1;
    chk("R1 ques bit3", query, 8'h08);
    ques_sum = 0; msg_avail = 1; #1;
    chk("R1 mav bit4", spoll_data, 8'h10);
    msg_avail = 0; oper_sum = 1; #1;
    chk("R1 oper bit7", query, 8'h80);
    oper_sum = 0; #1;
    chk("R6 mss off with sre zero", {7'd0, mss}, 8'h00);
  endtask

  task automatic t_esr();
    std_evt = 8'h01; step(); std_evt = 8'h00; #1;
    chk("R2 opc sticky", esr, 8'h01);
    std_evt = 8'h42; step(); std_evt = 8'h00; #1;
    chk("R2 bits 1,6 ignored", esr, 8'h01);
    std_evt = 8'hBC; step(); std_evt = 8'h00; step();
    chk("R2 accumulate", esr, 8'hBD);
    esr_rd = 1; std_evt = 8'h20; #1;
    chk("R3 read shows contents", esr, 8'hBD);
    step(); esr_rd = 0; std_evt = 0; #1;
    chk("R3 same-cycle event kept", esr, 8'h20);
    esr_rd = 1; step(); esr_rd = 0; #1;
    chk("R3 cleared", esr, 8'h00);
  endtask

  task automatic t_esb();
    std_evt = 8'h10; step(); std_evt = 0; #1;
    chk("R4 esb off when masked", query, 8'h00);
    ese_we = 1; ese_wdata = 8'h10; step(); ese_we = 0; #1;
    chk("R4 ese readback", ese, 8'h10);
    chk("R4 esb bit5", query, 8'h20);
    esr_rd = 1; step(); esr_rd = 0; #1;
    chk("R4 esb falls on clear", query, 8'h00);
  endtask

  task automatic t_sre_bit6();
    sre_we = 1; sre_wdata = 8'hFF; step(); sre_we = 0; #1;
    chk("R5 sre bit6 reads 0", sre, 8'hBF);
    chk("R5 no spurious mss", {7'd0, mss}, 8'h00);
    sre_we = 1; sre_wdata = 8'h40; step(); sre_we = 0; #1;
    chk("R5 sre bit6 only", sre, 8'h00);
    oper_sum = 1; err_q_ne = 1; step();
    chk("R5 bit6 mask no effect", {7'd0, mss}, 8'h00);
    chk("R5 no request", {7'd0, srq}, 8'h00);
    oper_sum = 0; err_q_ne = 0; step();
  endtask

  task automatic t_rqs();
    sre_we = 1; sre_wdata = 8'h80; step(); sre_we = 0;
    oper_sum = 1; #1;
    chk("R6 mss in query bit6", query, 8'hC0);
    chk("R7 not yet latched", {7'd0, srq}, 8'h00);
    step();
    chk("R7 srq set", {7'd0, srq}, 8'h01);
    oper_sum = 0; step(3);
    chk("R7 held after mss falls", {7'd0, srq}, 8'h01);
    chk("R7 query bit6 shows mss", query, 8'h00);
    chk("R8 poll byte bit6", spoll_data, 8'h40);
    spoll = 1; step(); spoll = 0; #1;
    chk("R8 cleared by poll", {7'd0, srq}, 8'h00);
  endtask

  task automatic t_collide();
    oper_sum = 1; step(); oper_sum = 0; step();
    chk("R9 setup latched", {7'd0, srq}, 8'h01);
    oper_sum = 1; spoll = 1; #1;
    chk("R9 poll byte", spoll_data, 8'hC0);
    step(); spoll = 0; #1;
    chk("R9 kept on coincident rise", {7'd0, srq}, 8'h01);
    spoll = 1; step(); spoll = 0; step(3);
    chk("R10 no retrigger while high", {7'd0, srq}, 8'h00);
    oper_sum = 0; step(); oper_sum = 1; step();
    chk("R10 new edge sets again", {7'd0, srq}, 8'h01);
    oper_sum = 0; spoll = 1; step(); spoll = 0;
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    t_reset();
    t_stb_bits();
    t_esr();
    t_esb();
    t_sre_bit6();
    t_rqs();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule